// File: doc/BRIEF.md
# Receive Chunked Copy Controller

This block sits between a receive packet buffer and a host copy engine. It holds the bookkeeping for one received packet: how many bytes are still waiting and how far into the packet the host has already read. Each host copy request carries a buffer length and a no-delay flag. The block answers each request with the length of the next DMA chunk, and tells the host whether the packet is now finished or whether more remains.

It watches buffer occupancy against a low and a high mark, and keeps a hysteretic low-occupancy state. While that state is set and zero-copy or delay-copy operation is enabled, the block cuts long chunks down to a small zero-copy size. The rest of the packet then stays in the buffer for later requests. A counter tracks how many packets have been partly but not fully copied. The block also flags configurations where the zero-copy size, the zero-copy threshold and the maximum copy length are out of order, reports high and empty occupancy, and pulses a request when a packet arrives into a nearly full buffer.

Top module: `rx_chunk_copier`

## Requirements
- R1: The chunk length is the smaller of the request buffer length and the bytes still remaining in the held packet, unless R2 applies.
- R2: When zero-copy or delay-copy is enabled, the request's no-delay flag is 0, the low state is 1, and the R1 length is strictly greater than the zero-copy threshold, the chunk length is the zero-copy size instead. A length equal to the threshold is not cut.
- R3: The low state is 0 after reset. It becomes 1 on the clock edge after occupancy is seen below the low mark. It becomes 0 on the clock edge after occupancy is seen above the high mark. Otherwise it keeps its value.
- R4: `cfgError` is 1 unless zero-copy size < zero-copy threshold and zero-copy threshold <= maximum copy length.
- R5: A chunk equal to the remaining bytes completes the packet. The done beat has `doneComplete`=1, `doneMore`=0 and `doneCopyLen` equal to the chunk. The packet is then released: `pktHeld` goes to 0 and no further request is accepted.
- R6: A shorter chunk gives `doneMore`=1, `doneComplete`=0 and `doneCopyLen`=0. The remaining byte count drops by the chunk length, which later chunks show.
- R7: `partialCount` rises by one on a packet's first partial chunk. It falls by one when a packet completes after at least one partial chunk. A packet that completes in one chunk leaves it unchanged. It is 0 after reset.
- R8: `statHigh` is 1 exactly when occupancy is strictly greater than the high mark. `statEmpty` is 1 exactly when occupancy is 0.
- R9: `highIrq` is a one-cycle pulse on the cycle after a `pktArrive` cycle in which occupancy is at or above the high mark. Otherwise it is 0.
- R10: `reqReady` is 1 only while a packet is held and no chunk is in flight. An accepted request sets `busy` for exactly one cycle. The `doneValid` pulse follows in the next cycle, and `busy` clears in that same cycle.
- R11: `pktLoad` loads a new packet of `pktLen` bytes at offset zero only when no packet is held. While a packet is held, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| occupancy | input | OCC_W | Current receive buffer occupancy in bytes |
| pktArrive | input | 1 | A packet is being written into the buffer this cycle |
| pktLoad | input | 1 | Start tracking a new packet |
| pktLen | input | LEN_W | Length of the packet being loaded |
| reqValid | input | 1 | Host copy request valid |
| reqReady | output | 1 | Request can be accepted |
| reqBufLen | input | LEN_W | Host buffer length of the request |
| reqNoDelay | input | 1 | Request forbids chunk cutting |
| cfgZeroCopy | input | 1 | Zero-copy operation enabled |
| cfgDelayCopy | input | 1 | Delay-copy operation enabled |
| cfgZcSize | input | LEN_W | Chunk size used when cutting |
| cfgZcMark | input | LEN_W | Zero-copy threshold |
| cfgMaxCopy | input | LEN_W | Maximum copy length |
| cfgLowMark | input | OCC_W | Low occupancy mark |
| cfgHighMark | input | OCC_W | High occupancy mark |
| doneValid | output | 1 | One-cycle chunk done pulse |
| doneLen | output | LEN_W | DMA length of the finished chunk |
| doneComplete | output | 1 | Chunk finished the packet |
| doneMore | output | 1 | Packet has bytes left |
| doneCopyLen | output | LEN_W | Copy length reported on completion, else 0 |
| busy | output | 1 | A chunk is in flight |
| pktHeld | output | 1 | A packet is being tracked |
| lowState | output | 1 | Hysteretic low-occupancy state |
| statHigh | output | 1 | Occupancy above the high mark |
| statEmpty | output | 1 | Buffer empty |
| highIrq | output | 1 | High-occupancy arrival pulse |
| partialCount | output | CNT_W | Packets partly copied |
| cfgError | output | 1 | Configuration ordering violated |

## Verification
A request accepted at one clock edge shows `busy` after that edge. Its done beat, with length and flags, appears after the following edge. The bench therefore pushes each expected beat into a queue when it drives the request. A monitor compares the beat at the falling edge of the cycle in which `doneValid` is high. The low state and `highIrq` settle one edge after the occupancy or arrival that causes them, so those checks wait two falling edges after the input changes. `statHigh`, `statEmpty`, `cfgError` and `reqReady` are combinational, and the bench reads them at the falling edge right after it drives the input.

// File: rtl/rxcc_pkg.sv
package rxcc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // request taken this cycle
    logic finish;  // in-flight chunk retires this cycle
  } rxccStrobes_t;
endpackage

// File: rtl/rxcc_ctrl.sv
module rxcc_ctrl
  import rxcc_pkg::*;
#(
  parameter int OCC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             pktHeld,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] cfgLowMark,
  input  logic [OCC_W-1:0] cfgHighMark,
  input  logic             pktArrive,
  output logic             reqReady,
  output logic             busy,
  output logic             doneValid,
  output logic             lowState,
  output logic             highIrq,
  output logic             statHigh,
  output logic             statEmpty,
  output rxccStrobes_t     strobes
);
  localparam logic [OCC_W-1:0] OCC_ZERO = '0;

  assign reqReady       = pktHeld && !busy;
  assign strobes.accept = reqValid && reqReady;
  assign strobes.finish = busy;
  assign statHigh       = occupancy > cfgHighMark;
  assign statEmpty      = occupancy == OCC_ZERO;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      doneValid <= 1'b0;
      lowState  <= 1'b0;
      highIrq   <= 1'b0;
    end else begin
      if (strobes.accept)      busy <= 1'b1;
      else if (strobes.finish) busy <= 1'b0;
      doneValid <= strobes.finish;
      // hysteresis: set below low mark, clear above high mark
      if (occupancy < cfgLowMark)       lowState <= 1'b1;
      else if (occupancy > cfgHighMark) lowState <= 1'b0;
      highIrq <= pktArrive && (occupancy >= cfgHighMark);
    end
  end
endmodule

// File: rtl/rxcc_dpath.sv
module rxcc_dpath
  import rxcc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxccStrobes_t     strobes,
  input  logic             pktLoad,
  input  logic [LEN_W-1:0] pktLen,
  input  logic [LEN_W-1:0] reqBufLen,
  input  logic             reqNoDelay,
  input  logic             cfgZeroCopy,
  input  logic             cfgDelayCopy,
  input  logic [LEN_W-1:0] cfgZcSize,
  input  logic [LEN_W-1:0] cfgZcMark,
  input  logic [LEN_W-1:0] cfgMaxCopy,
  input  logic             lowState,
  output logic             pktHeld,
  output logic [LEN_W-1:0] doneLen,
  output logic             doneComplete,
  output logic             doneMore,
  output logic [LEN_W-1:0] doneCopyLen,
  output logic [CNT_W-1:0] partialCount,
  output logic             cfgError
);
  localparam logic [LEN_W-1:0] LEN_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] offset;
  logic [LEN_W-1:0] chunkReg;
  logic [LEN_W-1:0] baseLen;
  logic [LEN_W-1:0] chunkNext;
  logic             cutOn;
  logic             lastChunk;

  assign baseLen   = (reqBufLen < remaining) ? reqBufLen : remaining;
  assign cutOn     = (cfgZeroCopy || cfgDelayCopy) && !reqNoDelay &&
                     lowState && (baseLen > cfgZcMark);
  assign chunkNext = cutOn ? cfgZcSize : baseLen;
  assign lastChunk = chunkReg == remaining;
  assign cfgError  = !((cfgZcSize < cfgZcMark) && (cfgZcMark <= cfgMaxCopy));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktHeld      <= 1'b0;
      remaining    <= '0;
      offset       <= '0;
      chunkReg     <= '0;
      doneLen      <= '0;
      doneComplete <= 1'b0;
      doneMore     <= 1'b0;
      doneCopyLen  <= '0;
      partialCount <= '0;
    end else begin
      if (pktLoad && !pktHeld && pktLen != LEN_ZERO) begin
        pktHeld   <= 1'b1;
        remaining <= pktLen;
        offset    <= '0;
      end
      if (strobes.accept) chunkReg <= chunkNext;
      if (strobes.finish) begin
        doneLen <= chunkReg;
        if (lastChunk) begin
          doneComplete <= 1'b1;
          doneMore     <= 1'b0;
          doneCopyLen  <= chunkReg;
          pktHeld      <= 1'b0;
          remaining    <= '0;
          offset       <= '0;
          if (offset != LEN_ZERO) partialCount <= partialCount - CNT_ONE;
        end else begin
          doneComplete <= 1'b0;
          doneMore     <= 1'b1;
          doneCopyLen  <= '0;
          remaining    <= remaining - chunkReg;
          offset       <= offset + chunkReg;
          if (offset == LEN_ZERO && chunkReg != LEN_ZERO)
            partialCount <= partialCount + CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/rx_chunk_copier.sv
module rx_chunk_copier
  import rxcc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int OCC_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCC_W-1:0] occupancy,
  input  logic             pktArrive,
  input  logic             pktLoad,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [LEN_W-1:0] reqBufLen,
  input  logic             reqNoDelay,
  input  logic             cfgZeroCopy,
  input  logic             cfgDelayCopy,
  input  logic [LEN_W-1:0] cfgZcSize,
  input  logic [LEN_W-1:0] cfgZcMark,
  input  logic [LEN_W-1:0] cfgMaxCopy,
  input  logic [OCC_W-1:0] cfgLowMark,
  input  logic [OCC_W-1:0] cfgHighMark,
  output logic             doneValid,
  output logic [LEN_W-1:0] doneLen,
  output logic             doneComplete,
  output logic             doneMore,
  output logic [LEN_W-1:0] doneCopyLen,
  output logic             busy,
  output logic             pktHeld,
  output logic             lowState,
  output logic             statHigh,
  output logic             statEmpty,
  output logic             highIrq,
  output logic [CNT_W-1:0] partialCount,
  output logic             cfgError
);
  rxccStrobes_t strobes;

  rxcc_ctrl #(.OCC_W(OCC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pktHeld(pktHeld),
    .occupancy(occupancy), .cfgLowMark(cfgLowMark), .cfgHighMark(cfgHighMark),
    .pktArrive(pktArrive), .reqReady(reqReady), .busy(busy),
    .doneValid(doneValid), .lowState(lowState), .highIrq(highIrq),
    .statHigh(statHigh), .statEmpty(statEmpty), .strobes(strobes)
  );

  rxcc_dpath #(.LEN_W(LEN_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pktLoad(pktLoad),
    .pktLen(pktLen), .reqBufLen(reqBufLen), .reqNoDelay(reqNoDelay),
    .cfgZeroCopy(cfgZeroCopy), .cfgDelayCopy(cfgDelayCopy),
    .cfgZcSize(cfgZcSize), .cfgZcMark(cfgZcMark), .cfgMaxCopy(cfgMaxCopy),
    .lowState(lowState), .pktHeld(pktHeld), .doneLen(doneLen),
    .doneComplete(doneComplete), .doneMore(doneMore),
    .doneCopyLen(doneCopyLen), .partialCount(partialCount),
    .cfgError(cfgError)
  );
endmodule

// File: rtl/rx_chunk_copier_chk.sv
module rx_chunk_copier_chk #(
  parameter int OCC_W = 16,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [OCC_W-1:0] occupancy,
  input logic [OCC_W-1:0] cfgLowMark,
  input logic [OCC_W-1:0] cfgHighMark,
  input logic             pktArrive,
  input logic             reqReady,
  input logic             busy,
  input logic             doneValid,
  input logic             doneComplete,
  input logic             doneMore,
  input logic             lowState,
  input logic             highIrq,
  input logic [CNT_W-1:0] partialCount
);
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (doneValid && !busy)); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busy); // R10
  AST_LOW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy < cfgLowMark) |=> lowState); // R3
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((occupancy > cfgHighMark) && (cfgLowMark <= cfgHighMark)) |=> !lowState); // R3
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((occupancy >= cfgLowMark) && (occupancy <= cfgHighMark)) |=> $stable(lowState)); // R3
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneComplete != doneMore)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (pktArrive && (occupancy >= cfgHighMark)) |=> highIrq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(pktArrive && (occupancy >= cfgHighMark)) |=> !highIrq); // R9
  AST_PARTIAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> $stable(partialCount)); // R7
endmodule

bind rx_chunk_copier rx_chunk_copier_chk #(.OCC_W(OCC_W), .CNT_W(CNT_W)) uChk (.*);

// File: tb/rx_chunk_copier_test.sv
`timescale 1ns/1ps
module rx_chunk_copier_test;
  localparam int LEN_W = 16;
  localparam int OCC_W = 16;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [OCC_W-1:0] occupancy = 16'd300;
  logic pktArrive = 1'b0;
  logic pktLoad = 1'b0;
  logic [LEN_W-1:0] pktLen = '0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [LEN_W-1:0] reqBufLen = '0;
  logic reqNoDelay = 1'b0;
  logic cfgZeroCopy = 1'b1;
  logic cfgDelayCopy = 1'b0;
  logic [LEN_W-1:0] cfgZcSize = 16'd64;
  logic [LEN_W-1:0] cfgZcMark = 16'd128;
  logic [LEN_W-1:0] cfgMaxCopy = 16'd1024;
  logic [OCC_W-1:0] cfgLowMark = 16'd100;
  logic [OCC_W-1:0] cfgHighMark = 16'd500;
  logic doneValid, doneComplete, doneMore, busy, pktHeld, lowState;
  logic statHigh, statEmpty, highIrq, cfgError;
  logic [LEN_W-1:0] doneLen, doneCopyLen;
  logic [CNT_W-1:0] partialCount;

  always #4 clk = ~clk;

  rx_chunk_copier #(.LEN_W(LEN_W), .OCC_W(OCC_W), .CNT_W(CNT_W)) uut (.*);

  typedef struct {
    logic [LEN_W-1:0] len;
    logic             complete;
    string            tag;
  } expBeat_t;

  expBeat_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: compare each done beat against the scoreboard
  always @(negedge clk) begin
    if (rstN && doneValid) begin
      if (expQ.size() == 0) begin
        check(0, "R10 unexpected done beat", 1, 0);
      end else begin
        expBeat_t e;
        e = expQ.pop_front();
        check(doneLen == e.len, {e.tag, " len"}, doneLen, e.len);
        check(doneComplete == e.complete, {e.tag, " complete"}, doneComplete, e.complete);
        check(doneMore == !e.complete, {e.tag, " R6 more"}, doneMore, !e.complete);
        check(doneCopyLen == (e.complete ? e.len : '0), {e.tag, " R5 copyLen"},
              doneCopyLen, e.complete ? e.len : 0);
      end
    end
  end

  task automatic loadPkt(input int len);
    @(negedge clk);
    pktLoad = 1'b1;
    pktLen = LEN_W'(len);
    @(negedge clk);
    pktLoad = 1'b0;
  endtask

  task automatic sendReq(input int bufLen, input bit nd, input int expLen,
                         input bit expComplete, input string tag);
    expBeat_t e;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    e.len = LEN_W'(expLen);
    e.complete = expComplete;
    e.tag = tag;
    expQ.push_back(e);
    reqValid = 1'b1;
    reqBufLen = LEN_W'(bufLen);
    reqNoDelay = nd;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1 && reqReady == 1'b0, "R10 busy after accept", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R10 busy cleared at done", busy, 0);
  endtask

  task automatic setOcc(input int occ);
    @(negedge clk);
    occupancy = OCC_W'(occ);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check(busy == 0 && doneValid == 0, "R10 reset idle", busy, 0);
    check(partialCount == 0, "R7 reset count", partialCount, 0);
    check(lowState == 0, "R3 reset low state", lowState, 0);
    check(reqReady == 0, "R10 no packet no ready", reqReady, 0);
    check(cfgError == 0, "R4 valid config", cfgError, 0);

    // plain chunking, low state off
    loadPkt(1000);
    check(reqReady == 1, "R11 load gives ready", reqReady, 1);
    sendReq(400, 0, 400, 0, "R1 buffer limited");
    check(partialCount == 1, "R7 first partial", partialCount, 1);
    sendReq(2000, 0, 600, 1, "R1 remaining limited");
    check(partialCount == 0, "R7 partial completes", partialCount, 0);
    check(reqReady == 0 && pktHeld == 0, "R5 packet released", pktHeld, 0);

    // hysteresis
    setOcc(50);
    @(negedge clk);
    check(lowState == 1, "R3 low set", lowState, 1);
    setOcc(300);
    @(negedge clk);
    check(lowState == 1, "R3 low held between marks", lowState, 1);

    // cutting in low state
    loadPkt(500);
    sendReq(300, 0, 64, 0, "R2 cut to zero-copy size");
    sendReq(200, 1, 200, 0, "R2 no-delay not cut");
    check(partialCount == 1, "R7 count once per packet", partialCount, 1);
    sendReq(100, 0, 100, 0, "R2 under threshold not cut");
    loadPkt(999);
    cfgZeroCopy = 1'b0;
    sendReq(1000, 0, 136, 1, "R11 load ignored, R1 remaining");
    check(partialCount == 0, "R7 back to zero", partialCount, 0);

    // delay-copy alone also cuts
    cfgDelayCopy = 1'b1;
    loadPkt(300);
    sendReq(400, 0, 64, 0, "R2 delay-copy cut");
    setOcc(600);
    @(negedge clk);
    check(lowState == 0, "R3 low cleared above high", lowState, 0);
    check(statHigh == 1, "R8 high above mark", statHigh, 1);
    sendReq(1000, 0, 236, 1, "R2 no cut outside low state");

    // high interrupt on arrival
    @(negedge clk);
    occupancy = 16'd500;
    pktArrive = 1'b1;
    @(negedge clk);
    pktArrive = 1'b0;
    check(statHigh == 0, "R8 not high at mark", statHigh, 0);
    check(highIrq == 1, "R9 irq at mark", highIrq, 1);
    @(negedge clk);
    check(highIrq == 0, "R9 irq one cycle", highIrq, 0);
    occupancy = 16'd499;
    pktArrive = 1'b1;
    @(negedge clk);
    pktArrive = 1'b0;
    check(highIrq == 0, "R9 no irq below mark", highIrq, 0);

    // empty and threshold boundary
    setOcc(0);
    check(statEmpty == 1, "R8 empty", statEmpty, 1);
    @(negedge clk);
    check(lowState == 1, "R3 low set at empty", lowState, 1);
    cfgZeroCopy = 1'b1;
    loadPkt(128);
    sendReq(500, 0, 128, 1, "R2 equal to threshold not cut");
    check(partialCount == 0, "R7 single chunk no change", partialCount, 0);
    occupancy = 16'd10;
    @(negedge clk);
    check(statEmpty == 0, "R8 not empty", statEmpty, 0);

    // configuration ordering
    cfgZcSize = 16'd128;
    @(negedge clk);
    check(cfgError == 1, "R4 size equals threshold", cfgError, 1);
    cfgZcSize = 16'd64;
    cfgZcMark = 16'd2000;
    @(negedge clk);
    check(cfgError == 1, "R4 threshold above max", cfgError, 1);
    cfgZcMark = 16'd1024;
    @(negedge clk);
    check(cfgError == 0, "R4 threshold equals max", cfgError, 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 all done beats seen", expQ.size(), 0);
    finishRun();
  end
endmodule